// File: doc/BRIEF.md
# Multi-mode FSK tone modulator

This block is the transmit side of a low-speed telephone-line modem. It turns a serial bit stream into a stream of signed sine amplitude samples. Each sample is taken from a single numerically controlled oscillator. The oscillator's frequency depends on the current transmit bit and on one of four operating modes:

| Mode | Mark (bit 1) | Space (bit 0) |
|------|--------------|---------------|
| V.21 originate | 980 Hz | 1180 Hz |
| V.21 answer | 1650 Hz | 1850 Hz |
| V.23 main channel | 1300 Hz | 2100 Hz |
| V.23 back channel | 390 Hz | 450 Hz |

Switching between frequencies never disturbs the phase, so the output waveform stays continuous across bit and mode changes. The samples feed a DAC and line filters that sit outside this block.

The block runs from the crystal-rate system clock. It also produces a free-running transmit clock at sixteen times the baud rate of the selected mode. The transmit data input is captured once per bit period, at the end of the sixteenth transmit clock period, so the data source can align its bit changes to that clock. When transmit is disabled, the output is silenced and the oscillator phase is frozen.

Top module: `fsk_tone_mod`

## Requirements
- R1: `mode` selects the tone pair: 0 = V.21 originate (mark 980 Hz, space 1180 Hz), 1 = V.21 answer (1650/1850 Hz), 2 = V.23 main (1300/2100 Hz), 3 = V.23 back channel (390/450 Hz). A latched bit of 1 is mark and 0 is space.
- R2: While `tx_en` is 1, a 32-bit phase advances on every clock by round(f * 2^32 / CLK_HZ), where f is the tone selected by the current `mode` and the latched bit.
- R3: A change of the latched bit or of `mode` changes only the step size. The phase keeps its value through the change.
- R4: `sample_o` equals round(511 * sin(2*pi*(a + 0.5)/256)) within one LSB. Here `a` is bits 31..24 of the phase as it was one clock earlier. The output never takes the value -512.
- R5: While `tx_en` is 0, `sample_o` is 0 from the next clock onward and the phase is held. Re-enabling resumes from the held phase.
- R6: `tx_clk_o` has a period of DIV clocks: DIV_V23 in mode 2, DIV_BACK in mode 3, DIV_V21 in modes 0 and 1. It is low for the first DIV/2 clocks of each period and high for the rest. It runs whatever the value of `tx_en`.
- R7: `tx_bit` is captured only at the clock edge that ends every sixteenth `tx_clk_o` period. Its value at any other edge has no effect on the output.
- R8: Synchronous reset (`rst` = 1) clears the phase, `sample_o` and `tx_clk_o` to 0, sets the latched bit to mark (1), and restarts the divider and period counters.
- R9: After a `mode` change, if the divider count is already at or past the new mode's last count, the period ends at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| mode | input | 2 | Tone pair and baud selection (R1) |
| tx_bit | input | 1 | Serial transmit data |
| sample_o | output | SAMPLE_W (10) | Signed sine sample |
| tx_clk_o | output | 1 | Transmit clock, 16 x baud |

## Verification
The bench builds the block with CLK_HZ = 110592 and divisors of 8, 4 and 12. These values are much smaller than the defaults of 11059200, 2304, 576 and 9216. With the lower clock rate, every tone steps through all 256 sine table addresses within a few hundred clocks. With the short divisors, each mode completes dozens of bit periods, so its bit captures and mode-change wraps all occur in under ten thousand clocks.

The bench compares the sample and the transmit clock on every cycle against an arithmetic reference. That reference is built from the tone list, the rounding rule for the step size and the real sine function. The bench drives several input patterns: constant mark, constant space, slow alternation, and per-cycle random data (which tests the capture rule). It also inserts disable gaps and changes the mode mid-period.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

    typedef enum logic [1:0] {
        MODE_V21_ORIG = 2'd0,
        MODE_V21_ANS  = 2'd1,
        MODE_V23_MAIN = 2'd2,
        MODE_V23_BACK = 2'd3
    } fsk_mode_e;

    // pi in Q30 fixed point
    localparam logic [63:0] PI_Q30  = 64'd3373259426;
    localparam logic [63:0] ONE_Q30 = 64'd1 << 30;

    // Tone frequency in Hz for a mode and a bit (1 = mark).
    function automatic int unsigned tone_hz(input logic [1:0] mode, input logic mark);
        case (mode)
            2'd0:    return mark ? 980  : 1180;
            2'd1:    return mark ? 1650 : 1850;
            2'd2:    return mark ? 1300 : 2100;
            default: return mark ? 390  : 450;
        endcase
    endfunction

    // Phase step per clock, rounded half up.
    function automatic logic [63:0] phase_step(input int unsigned hz,
                                               input int unsigned clk_hz,
                                               input int unsigned pw);
        logic [63:0] num;
        num = (64'(hz) << pw) + 64'(clk_hz / 2);
        return num / 64'(clk_hz);
    endfunction

    // Quarter-wave entry k of qn entries: round(amp * sin((2k+1)*pi/(4*qn))).
    // Seventh-order odd polynomial evaluated in Horner form, Q30.
    function automatic logic [31:0] quarter_sine(input int unsigned k,
                                                 input int unsigned qn,
                                                 input int unsigned amp);
        logic [63:0] x, x2, t, s, r;
        x  = (64'(2 * k + 1) * PI_Q30) / 64'(4 * qn);
        x2 = (x * x) >> 30;
        t  = ONE_Q30 - x2 / 42;
        t  = ONE_Q30 - ((x2 * t) >> 30) / 20;
        t  = ONE_Q30 - ((x2 * t) >> 30) / 6;
        s  = (x * t) >> 30;
        r  = (s * 64'(amp) + (ONE_Q30 >> 1)) >> 30;
        return r[31:0];
    endfunction

endpackage

// File: rtl/fsk_baud_gen.sv
module fsk_baud_gen #(
    parameter int unsigned DIV_V21  = 2304,
    parameter int unsigned DIV_V23  = 576,
    parameter int unsigned DIV_BACK = 9216,
    parameter int unsigned TICKS    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       tx_bit,
    output logic       tx_clk,
    output logic       sym_bit,
    output logic       sym_strobe,
    output logic       div_wrap
);
    localparam int unsigned DIV_MAX = (DIV_BACK > DIV_V21) ?
        ((DIV_BACK > DIV_V23) ? DIV_BACK : DIV_V23) :
        ((DIV_V21 > DIV_V23) ? DIV_V21 : DIV_V23);
    localparam int unsigned CNT_W  = $clog2(DIV_MAX);
    localparam int unsigned TICK_W = $clog2(TICKS);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [TICK_W-1:0] tick;
        logic              clk_out;
        logic              bit_lat;
    } baud_state_t;

    baud_state_t st_d, st_q;
    logic [CNT_W-1:0] div_last, div_half;
    logic             wrap, strobe;

    always_comb begin
        case (mode)
            2'd2:    begin div_last = CNT_W'(DIV_V23 - 1);  div_half = CNT_W'(DIV_V23 / 2);  end
            2'd3:    begin div_last = CNT_W'(DIV_BACK - 1); div_half = CNT_W'(DIV_BACK / 2); end
            default: begin div_last = CNT_W'(DIV_V21 - 1);  div_half = CNT_W'(DIV_V21 / 2);  end
        endcase
        wrap     = (st_q.cnt >= div_last);
        strobe   = wrap && (st_q.tick == TICK_W'(TICKS - 1));
        st_d     = st_q;
        st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        if (wrap) begin
            st_d.tick = (st_q.tick == TICK_W'(TICKS - 1)) ? '0 : st_q.tick + 1'b1;
        end
        if (strobe) begin
            st_d.bit_lat = tx_bit;
        end
        st_d.clk_out = (st_d.cnt >= div_half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: '0, tick: '0, clk_out: 1'b0, bit_lat: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_clk     = st_q.clk_out;
    assign sym_bit    = st_q.bit_lat;
    assign sym_strobe = strobe;
    assign div_wrap   = wrap;
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
    import fsk_tone_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 11059200,
    parameter int unsigned PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [1:0]         mode,
    input  logic               sym_bit,
    output logic [PHASE_W-1:0] phase
);
    localparam int unsigned N_STEP = 8;

    logic [PHASE_W-1:0] step_tab [N_STEP];
    logic [PHASE_W-1:0] phase_d, phase_q;

    for (genvar g = 0; g < N_STEP; g++) begin : g_step
        assign step_tab[g] = PHASE_W'(phase_step(
            tone_hz(2'(g / 2), 1'(g % 2)), CLK_HZ, PHASE_W));
    end

    always_comb begin
        phase_d = en ? phase_q + step_tab[{mode, sym_bit}] : phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
    import fsk_tone_pkg::*;
#(
    parameter int unsigned LUT_W    = 8,
    parameter int unsigned SAMPLE_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [LUT_W-1:0]           addr,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int unsigned IDX_W = LUT_W - 2;
    localparam int unsigned QN    = 2 ** IDX_W;
    localparam int unsigned AMP   = 2 ** (SAMPLE_W - 1) - 1;

    logic [SAMPLE_W-2:0]        rom [QN];
    logic [1:0]                 quad;
    logic [IDX_W-1:0]           ridx;
    logic signed [SAMPLE_W-1:0] mag, sample_d, sample_q;

    for (genvar g = 0; g < QN; g++) begin : g_rom
        assign rom[g] = (SAMPLE_W-1)'(quarter_sine(g, QN, AMP));
    end

    always_comb begin
        quad     = addr[LUT_W-1 -: 2];
        ridx     = quad[0] ? ~addr[IDX_W-1:0] : addr[IDX_W-1:0];
        mag      = $signed({1'b0, rom[ridx]});
        sample_d = en ? (quad[1] ? -mag : mag) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
        end else begin
            sample_q <= sample_d;
        end
    end

    assign sample = sample_q;
endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod #(
    parameter int unsigned CLK_HZ   = 11059200,
    parameter int unsigned PHASE_W  = 32,
    parameter int unsigned LUT_W    = 8,
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned DIV_V21  = 2304,
    parameter int unsigned DIV_V23  = 576,
    parameter int unsigned DIV_BACK = 9216
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tx_en,
    input  logic [1:0]                 mode,
    input  logic                       tx_bit,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic                       tx_clk_o
);
    localparam int unsigned TICKS = 16;

    logic               sym_bit;
    logic               sym_strobe;
    logic               div_wrap;
    logic [PHASE_W-1:0] phase;

    fsk_baud_gen #(
        .DIV_V21 (DIV_V21),
        .DIV_V23 (DIV_V23),
        .DIV_BACK(DIV_BACK),
        .TICKS   (TICKS)
    ) u_baud (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .tx_bit    (tx_bit),
        .tx_clk    (tx_clk_o),
        .sym_bit   (sym_bit),
        .sym_strobe(sym_strobe),
        .div_wrap  (div_wrap)
    );

    fsk_phase_acc #(
        .CLK_HZ (CLK_HZ),
        .PHASE_W(PHASE_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (tx_en),
        .mode   (mode),
        .sym_bit(sym_bit),
        .phase  (phase)
    );

    fsk_sine_rom #(
        .LUT_W   (LUT_W),
        .SAMPLE_W(SAMPLE_W)
    ) u_rom (
        .clk   (clk),
        .rst   (rst),
        .en    (tx_en),
        .addr  (phase[PHASE_W-1 -: LUT_W]),
        .sample(sample_o)
    );
endmodule

// File: rtl/fsk_tone_mod_chk.sv
module fsk_tone_mod_chk #(
    parameter int unsigned PHASE_W  = 32,
    parameter int unsigned SAMPLE_W = 10
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tx_en,
    input logic signed [SAMPLE_W-1:0] sample,
    input logic                       tx_clk,
    input logic                       sym_bit,
    input logic                       sym_strobe,
    input logic                       div_wrap,
    input logic [PHASE_W-1:0]         phase
);
    localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (sample == '0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> $stable(phase));

    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_strobe |=> $stable(sym_bit));

    // R6
    clk_low_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        div_wrap |=> !tx_clk);

    // R4
    sample_range_chk: assert property (@(posedge clk) disable iff (rst)
        sample != MOST_NEG);
endmodule

bind fsk_tone_mod fsk_tone_mod_chk #(
    .PHASE_W (PHASE_W),
    .SAMPLE_W(SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .sample    (sample_o),
    .tx_clk    (tx_clk_o),
    .sym_bit   (sym_bit),
    .sym_strobe(sym_strobe),
    .div_wrap  (div_wrap),
    .phase     (phase)
);

// File: tb/sim_fsk_tone_mod.sv
module sim_fsk_tone_mod;
    localparam int CLK_HZ   = 110592;
    localparam int DIV_V21  = 8;
    localparam int DIV_V23  = 4;
    localparam int DIV_BACK = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tx_en = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic              tx_bit = 1'b1;
    logic signed [9:0] sample_o;
    logic              tx_clk_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    fsk_tone_mod #(
        .CLK_HZ  (CLK_HZ),
        .DIV_V21 (DIV_V21),
        .DIV_V23 (DIV_V23),
        .DIV_BACK(DIV_BACK)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .mode    (mode),
        .tx_bit  (tx_bit),
        .sample_o(sample_o),
        .tx_clk_o(tx_clk_o)
    );

    // R1 tone list
    function automatic int tone(input int m, input logic b);
        case (m)
            0:       return b ? 980  : 1180;
            1:       return b ? 1650 : 1850;
            2:       return b ? 1300 : 2100;
            default: return b ? 390  : 450;
        endcase
    endfunction

    // R2 step size
    function automatic logic [31:0] step(input int m, input logic b);
        real r;
        r = real'(tone(m, b)) * 4294967296.0 / real'(CLK_HZ);
        return 32'($rtoi($floor(r + 0.5)));
    endfunction

    // R4 sample value
    function automatic int exp_sample(input int a);
        real r;
        r = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 256.0);
        if (r >= 0.0) return $rtoi($floor(r + 0.5));
        return -$rtoi($floor(-r + 0.5));
    endfunction

    function automatic int divisor(input int m);
        if (m == 2) return DIV_V23;
        if (m == 3) return DIV_BACK;
        return DIV_V21;
    endfunction

    // reference model, updated at the same edges as the design
    int          m_cnt, m_tick, m_sample;
    logic        m_bit, m_clk;
    logic [31:0] m_phase;

    always @(posedge clk) begin
        int  dv, nxt;
        bit  wr;
        if (rst) begin
            m_cnt <= 0; m_tick <= 0; m_bit <= 1'b1; m_clk <= 1'b0;
            m_phase <= '0; m_sample <= 0;
        end else begin
            dv  = divisor(int'(mode));
            wr  = (m_cnt >= dv - 1);          // R9
            nxt = wr ? 0 : m_cnt + 1;
            m_cnt <= nxt;
            if (wr) m_tick <= (m_tick + 1) % 16;
            if (wr && m_tick == 15) m_bit <= tx_bit; // R7
            m_clk <= (nxt >= dv / 2);                // R6
            if (tx_en) m_phase <= m_phase + step(int'(mode), m_bit); // R2 R3
            m_sample <= tx_en ? exp_sample(int'(m_phase[31:24])) : 0; // R4 R5
        end
    end

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        int d;
        if (!rst && !done) begin
            cycles++;
            checks++;
            d = int'(sample_o) - m_sample;
            if (d > 1 || d < -1) begin
                failures++;
                $display("FAIL R1 R2 R3 R4 R5 R7 sample mode=%0d actual=%0d expected=%0d",
                         mode, sample_o, m_sample);
            end
            checks++;
            if (tx_clk_o !== m_clk) begin
                failures++;
                $display("FAIL R6 R9 tx_clk mode=%0d actual=%0b expected=%0b",
                         mode, tx_clk_o, m_clk);
            end
        end
    end

    task automatic run(input int m, input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mode = 2'(m);
            case (pat)
                0: tx_bit = 1'b1;
                1: tx_bit = 1'b0;
                2: tx_bit = ((i / 50) % 2) == 1;
                default: tx_bit = 1'($urandom_range(0, 1));
            endcase
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        checks++;
        if (sample_o !== 10'sd0 || tx_clk_o !== 1'b0) begin
            failures++;
            $display("FAIL R8 reset actual=%0d/%0b expected=0/0", sample_o, tx_clk_o);
        end
        rst = 1'b0;
        // R6 clock runs while disabled; R5 silent output
        run(0, 100, 0);
        tx_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            run(m, 16 * divisor(m) * 3, 0); // mark
            run(m, 16 * divisor(m) * 3, 1); // space
            run(m, 16 * divisor(m) * 4, 2); // slow alternation
            run(m, 16 * divisor(m) * 4, 3); // R7 random per cycle
            // R5 disable gap then resume from held phase
            @(negedge clk); tx_en = 1'b0;
            run(m, 37, 3);
            checks++;
            if (sample_o !== 10'sd0) begin
                failures++;
                $display("FAIL R5 disabled sample actual=%0d expected=0", sample_o);
            end
            @(negedge clk); tx_en = 1'b1;
        end
        // R9 mode changes mid period, long to short divisor
        for (int k = 0; k < 40; k++) begin
            run(3, 5 + (k % 7), 3);
            run(2, 3 + (k % 5), 3);
            run(0, 6 + (k % 3), 3);
        end
        // R8 reset mid run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        checks++;
        if (sample_o !== 10'sd0 || tx_clk_o !== 1'b0) begin
            failures++;
            $display("FAIL R8 reset mid-run actual=%0d/%0b expected=0/0", sample_o, tx_clk_o);
        end
        rst = 1'b0;
        run(1, 16 * DIV_V21 * 2, 2);
        finish_run();
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule